// File: doc/BRIEF.md
# SPI Configuration Port Command Responder

This block models the target side of a programmable device's SPI configuration port. A host that pushes a configuration image over SPI can talk to it in a testbench, or it can stand in for the real target in a larger simulation. The block samples SPI mode 0 traffic: MOSI is taken on rising SCLK and MISO changes on falling SCLK. The three SPI inputs pass through synchronisers into the system clock domain.

Each chip-select frame begins with a one-byte opcode. Two read opcodes return a 32-bit word, either a fixed identifier or a status word, after three stuffing bytes. The other opcodes control a write-enable gate, start a memory clear that completes after a programmable delay, reset the state, or stream image bytes, which the block counts. After enough bytes have arrived, a write-disable sets a done flag. Nothing inside the streamed image is interpreted.

Top module: `spi_cfg_responder`

## Requirements
- R1: After reset, wr_en_o, cleared_o, done_o, data_bytes_o and spi_miso are all zero.
- R2: Only the first byte of a frame is decoded as an opcode. An unknown opcode, or a known opcode byte in a later position of a frame, changes no state.
- R3: Opcode 0x07 is followed by three don't-care bytes. During the next 32 SCLK cycles the ID_WORD parameter (default 0xC2088080) is shifted out on MISO, most significant bit first, with each bit valid at a rising SCLK edge.
- R4: Opcode 0x09 returns the status word in the same frame layout as R3. Bit 16 of the status word is the cleared flag, bit 14 is the done flag, and every other bit is zero. The word reads 0x00010000 right after a clear has completed, before any data.
- R5: Opcode 0x4A sets wr_en_o. Opcode 0x4F clears wr_en_o.
- R6: Opcode 0x70 is accepted only while wr_en_o is 1. Otherwise it has no effect.
- R7: An accepted clear zeroes data_bytes_o. CLEAR_DELAY clock cycles later, cleared_o rises and done_o falls in the same cycle.
- R8: In a frame opened by 0x41, the three bytes after the opcode are skipped. Each later complete byte before chip select rises adds one to data_bytes_o (saturating) and drops cleared_o, but only while wr_en_o is 1.
- R9: Opcode 0x4F sets done_o when data_bytes_o is at least MIN_BYTES. Otherwise done_o is left as it is.
- R10: Opcode 0x71 clears wr_en_o, cleared_o and done_o, and cancels a clear that is still pending.
- R11: spi_miso is 0 whenever spi_cs_n is high or the current frame has no response active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock from the host |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Host-to-target serial data |
| spi_miso | output | 1 | Target-to-host serial data |
| wr_en_o | output | 1 | Write-enable gate state |
| cleared_o | output | 1 | Configuration memory cleared flag |
| done_o | output | 1 | Configuration done flag |
| data_bytes_o | output | CNT_W | Image bytes counted since the last accepted clear |

## Verification
The checker evaluates the following on every cycle:
- MISO stays quiet while chip select is high.
- Done can only rise with the byte count at or above the minimum.
- A rising cleared flag never leaves done set.
- The byte count grows only while the gate was open.
- A counted byte always leaves the cleared flag low.

Only the bench scenarios can show the rest:
- The bit order and content of the ID and status answers.
- The clear delay window.
- That a rejected clear or a misplaced opcode changes nothing.
- That a reset command cancels a pending clear.

// File: rtl/spi_cfg_responder.sv
module spi_cfg_responder #(
  parameter logic [31:0] ID_WORD     = 32'hC2088080,
  parameter int          CLEAR_DELAY = 40,
  parameter int          MIN_BYTES   = 4,
  parameter int          CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_sclk,
  input  logic             spi_cs_n,
  input  logic             spi_mosi,
  output logic             spi_miso,
  output logic             wr_en_o,
  output logic             cleared_o,
  output logic             done_o,
  output logic [CNT_W-1:0] data_bytes_o
);

  localparam int DLY_W = $clog2(CLEAR_DELAY + 1);
  localparam logic [7:0] OP_ID    = 8'h07;
  localparam logic [7:0] OP_STAT  = 8'h09;
  localparam logic [7:0] OP_CLEAR = 8'h70;
  localparam logic [7:0] OP_RFSH  = 8'h71;
  localparam logic [7:0] OP_WEN   = 8'h4A;
  localparam logic [7:0] OP_WDIS  = 8'h4F;
  localparam logic [7:0] OP_WINC  = 8'h41;

  logic [2:0]       sclk_q, cs_q;
  logic [1:0]       mosi_q;
  logic [2:0]       bit_cnt, byte_idx;
  logic [7:0]       rx_byte, opcode;
  logic             pend, resp_on;
  logic [31:0]      tx_sr;
  logic             clr_busy;
  logic [DLY_W-1:0] clr_cnt;

  wire       sel       = ~cs_q[1];
  wire       rise      = sel & sclk_q[1] & ~sclk_q[2];
  wire       fall      = sel & ~sclk_q[1] & sclk_q[2];
  wire [7:0] byte_now  = {rx_byte[6:0], mosi_q[1]};
  wire       byte_done = rise & (bit_cnt == 3'd7);
  wire       cmd_hit   = byte_done & (byte_idx == 3'd0);
  wire       data_hit  = byte_done & (byte_idx == 3'd4) & (opcode == OP_WINC) & wr_en_o;
  wire [31:0] status_w = {15'd0, cleared_o, 1'b0, done_o, 14'd0};

  assign spi_miso = ~spi_cs_n & resp_on & tx_sr[31];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], spi_sclk};
      cs_q   <= {cs_q[1:0], spi_cs_n};
      mosi_q <= {mosi_q[0], spi_mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      byte_idx <= '0;
      rx_byte  <= '0;
      opcode   <= '0;
      pend     <= 1'b0;
      resp_on  <= 1'b0;
      tx_sr    <= '0;
    end else if (!sel) begin
      bit_cnt  <= '0;
      byte_idx <= '0;
      pend     <= 1'b0;
      resp_on  <= 1'b0;
    end else begin
      if (rise) begin
        rx_byte <= byte_now;
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          if (byte_idx == 3'd0) opcode <= byte_now;
          if (byte_idx != 3'd4) byte_idx <= byte_idx + 3'd1;
          if (byte_idx == 3'd3 && (opcode == OP_ID || opcode == OP_STAT)) pend <= 1'b1;
        end
      end
      if (fall) begin
        if (pend) begin
          tx_sr   <= (opcode == OP_ID) ? ID_WORD : status_w;
          pend    <= 1'b0;
          resp_on <= 1'b1;
        end else if (resp_on) begin
          tx_sr <= {tx_sr[30:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_o      <= 1'b0;
      cleared_o    <= 1'b0;
      done_o       <= 1'b0;
      data_bytes_o <= '0;
      clr_busy     <= 1'b0;
      clr_cnt      <= '0;
    end else begin
      if (clr_busy) begin
        if (clr_cnt == DLY_W'(1)) begin
          cleared_o <= 1'b1;
          done_o    <= 1'b0;
          clr_busy  <= 1'b0;
        end else begin
          clr_cnt <= clr_cnt - DLY_W'(1);
        end
      end
      if (data_hit) begin
        cleared_o <= 1'b0;
        if (data_bytes_o != '1) data_bytes_o <= data_bytes_o + CNT_W'(1);
      end
      if (cmd_hit) begin
        case (byte_now)
          OP_WEN: wr_en_o <= 1'b1;
          OP_WDIS: begin
            wr_en_o <= 1'b0;
            if (data_bytes_o >= CNT_W'(MIN_BYTES)) done_o <= 1'b1;
          end
          OP_CLEAR: if (wr_en_o) begin
            clr_busy     <= 1'b1;
            clr_cnt      <= DLY_W'(CLEAR_DELAY);
            data_bytes_o <= '0;
          end
          OP_RFSH: begin
            wr_en_o   <= 1'b0;
            cleared_o <= 1'b0;
            done_o    <= 1'b0;
            clr_busy  <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/spi_cfg_responder_chk.sv
module spi_cfg_responder_chk #(
  parameter int MIN_BYTES = 4,
  parameter int CNT_W     = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             spi_cs_n,
  input logic             spi_miso,
  input logic             wr_en_o,
  input logic             cleared_o,
  input logic             done_o,
  input logic [CNT_W-1:0] data_bytes_o
);

  // R11
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_miso);

  // R9
  done_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (data_bytes_o >= CNT_W'(MIN_BYTES)));

  // R7
  clear_drops_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cleared_o) |-> !done_o);

  // R8
  data_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_bytes_o > $past(data_bytes_o)) |-> $past(wr_en_o));

  // R8
  data_drops_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_bytes_o > $past(data_bytes_o)) |-> !cleared_o);

endmodule

bind spi_cfg_responder spi_cfg_responder_chk #(.MIN_BYTES(MIN_BYTES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
  .wr_en_o(wr_en_o), .cleared_o(cleared_o), .done_o(done_o), .data_bytes_o(data_bytes_o)
);

// File: tb/spi_cfg_responder_bench.sv
module spi_cfg_responder_bench;
  localparam int D = 200;
  localparam int H = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, wr_en, cleared, done;
  logic [15:0] cnt;
  int n_run = 0, n_fail = 0;
  bit finished = 0;
  logic [31:0] rx_word;
  logic miso_seen;
  logic [31:0] exp_q[$];
  string tag_q[$];
  event word_ev;

  always #10 clk = ~clk;

  spi_cfg_responder #(.CLEAR_DELAY(D), .MIN_BYTES(4), .CNT_W(16)) u_spi_cfg_responder (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .wr_en_o(wr_en), .cleared_o(cleared), .done_o(done), .data_bytes_o(cnt)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic frame(input int n, input logic [63:0] bytes);
    @(negedge clk);
    cs_n = 1'b0;
    miso_seen = 1'b0;
    rx_word = '0;
    repeat (H) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      for (int b = 0; b < 8; b++) begin
        sclk = 1'b0;
        mosi = bytes[63 - 8*k - b];
        repeat (H) @(negedge clk);
        miso_seen = miso_seen | miso;
        if (k >= 4) rx_word = {rx_word[30:0], miso};
        sclk = 1'b1;
        repeat (H) @(negedge clk);
      end
    end
    sclk = 1'b0;
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] op, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    frame(8, {op, 56'h0});
    -> word_ev;
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(word_ev);
      if (exp_q.size() == 0) begin
        n_run++; n_fail++;
        $display("FAIL scoreboard: actual %h expected none", rx_word);
      end else begin
        check(tag_q.pop_front(), rx_word, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset flags", {29'd0, wr_en, cleared, done}, 32'd0);
    check("R1 reset count", {16'd0, cnt}, 32'd0);
    check("R1 reset miso", {31'd0, miso}, 32'd0);

    rd(8'h07, 32'hC2088080, "R3 id read");
    rd(8'h09, 32'h00000000, "R4 status after reset");

    frame(1, {8'h70, 56'h0});
    repeat (D + 50) @(negedge clk);
    check("R6 clear without enable", {31'd0, cleared}, 32'd0);

    frame(1, {8'h4A, 56'h0});
    check("R5 write enable", {31'd0, wr_en}, 32'd1);
    check("R11 miso quiet in non-read frame", {31'd0, miso_seen}, 32'd0);

    frame(1, {8'h70, 56'h0});
    repeat (50) @(negedge clk);
    check("R7 cleared still low in delay", {31'd0, cleared}, 32'd0);
    repeat (D - 50) @(negedge clk);
    check("R7 cleared after delay", {31'd0, cleared}, 32'd1);
    rd(8'h09, 32'h00010000, "R4 status after clear");

    frame(6, {8'h41, 24'hFFFFFF, 8'hA5, 8'h3C, 16'h0});
    check("R8 two bytes counted", {16'd0, cnt}, 32'd2);
    check("R8 data drops cleared", {31'd0, cleared}, 32'd0);

    frame(1, {8'h4F, 56'h0});
    check("R5 write disable", {31'd0, wr_en}, 32'd0);
    check("R9 done below minimum", {31'd0, done}, 32'd0);

    frame(7, {8'h41, 24'hFFFFFF, 24'h112233, 8'h0});
    check("R8 no count while disabled", {16'd0, cnt}, 32'd2);

    frame(2, {8'h55, 8'h4A, 48'h0});
    check("R2 opcode only in first byte", {31'd0, wr_en}, 32'd0);

    frame(1, {8'h4A, 56'h0});
    frame(7, {8'h41, 24'hFFFFFF, 24'h445566, 8'h0});
    check("R8 count to five", {16'd0, cnt}, 32'd5);
    frame(1, {8'h4F, 56'h0});
    check("R9 done at minimum", {31'd0, done}, 32'd1);
    rd(8'h09, 32'h00004000, "R4 status done");

    frame(1, {8'h4A, 56'h0});
    frame(1, {8'h70, 56'h0});
    check("R7 count zeroed on clear", {16'd0, cnt}, 32'd0);
    check("R7 done held during delay", {31'd0, done}, 32'd1);
    repeat (D + 10) @(negedge clk);
    check("R7 done dropped with cleared", {30'd0, cleared, done}, 32'd2);

    frame(1, {8'h71, 56'h0});
    check("R10 refresh flags", {29'd0, wr_en, cleared, done}, 32'd0);

    frame(1, {8'h4A, 56'h0});
    frame(1, {8'h70, 56'h0});
    frame(1, {8'h71, 56'h0});
    repeat (D + 50) @(negedge clk);
    check("R10 refresh cancels clear", {31'd0, cleared}, 32'd0);
    check("R11 miso idle", {31'd0, miso}, 32'd0);

    repeat (10) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_run++; n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule